// File: doc/BRIEF.md
# Flash Block Erase and Verify Sequencer

This controller carries out the complete erase procedure for one flash block chosen by the requester. A single start pulse with a block index launches it. It raises the array control bits in order: write enable, then erase setup, then erase. It drops them again in the reverse order, then enters verify mode. Every minimum settling time is enforced by a shared down-counter, and so is the ceiling on the erase pulse. All times are parameters given in clock cycles. No preprogramming to zeros is done before the erase.

During the pulse window the sequencer arms an external watchdog, with a period longer than the worst-case erase window. In verify mode it walks the block one 16-bit word at a time. For each word it makes a dummy all-ones write, waits, then reads the word back. The first word that is not all ones ends the pass, and another erase pulse follows. The number of erase/verify passes is capped. When the cap is reached without a clean pass, the sequencer still runs the normal teardown and then reports failure.

Top module: `flash_erase_seq`

## Requirements
- R1: A start pulse while idle (busy low) raises write enable (ctl bit 0). The one-hot block select (bit k for block index k) appears no fewer than T_SSWE cycles later. Start pulses while busy have no effect.
- R2: The watchdog arm output is high, and wdt_period exceeds T_SE+T_SESU+T_CE+T_CESU, whenever erase setup (ctl bit 1) is high. It is low during verify.
- R3: Erase setup rises at least T_SESU cycles before erase (ctl bit 2). Erase is only high while setup and write enable are high. Each erase pulse lasts at most T_SE cycles; this design uses exactly T_SE.
- R4: After erase falls, erase setup stays high for at least T_CE more cycles.
- R5: Verify (ctl bit 3) is high at least T_SEV cycles before the first dummy write of a pass. Every dummy write drives all ones.
- R6: Each read occurs at least T_SEVR cycles after the dummy write, at the address just written. Addresses start at block base (index × 2·BLK_WORDS bytes) and step by 2.
- R7: An unerased word ends the verify pass at once, and a new erase pulse follows. At most MAX_PASS erase pulses occur per request.
- R8: After verify falls, write enable and block select clear at least T_CEV cycles later. done pulses for one cycle at least T_CSWE cycles after that.
- R9: If MAX_PASS passes end without a clean verify, fail is high in the done cycle; otherwise fail is low.
- R10: No memory write occurs outside verify mode (no preprogramming).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| blk_idx | input | BSW | Index of block to erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Erase not verified after MAX_PASS passes (valid with done) |
| ctl | output | 4 | Array control bits: 0 write enable, 1 erase setup, 2 erase, 3 verify |
| blk_sel | output | NBLK | One-hot block select |
| wdt_arm | output | 1 | Watchdog armed |
| wdt_period | output | CNT_W | Watchdog period in cycles while armed, else 0 |
| mem_we | output | 1 | Dummy write strobe |
| mem_re | output | 1 | Verify read strobe |
| mem_addr | output | ADDR_W | Byte address for write/read |
| mem_wdata | output | 16 | Dummy write data |
| mem_rdata | input | 16 | Read data, sampled in the read cycle |

## Verification
The bench models an array in which each word needs a programmable number of erase pulses before it reads all ones. Reads return the word at the most recently latched write address. The first pattern, with every word clean after one pulse, measures every settling gap and the pulse length. A single slow word placed mid-block separates a correct early abort, with a short read count per pass, from a design that finishes the whole pass or never retries. A word that never clears tells a capped pass count and a fail flag apart from endless retrying. A start issued mid-run checks that the selected block and the pulse count stay those of the first request.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NBLK      = 4,
  parameter int BSW       = (NBLK > 1) ? $clog2(NBLK) : 1,
  parameter int BLK_WORDS = 8,
  parameter int ADDR_W    = 10,
  parameter int CNT_W     = 16,
  parameter int T_SSWE    = 3,
  parameter int T_SESU    = 4,
  parameter int T_SE      = 20,
  parameter int T_CE      = 3,
  parameter int T_CESU    = 2,
  parameter int T_SEV     = 3,
  parameter int T_SEVR    = 2,
  parameter int T_CEV     = 3,
  parameter int T_CSWE    = 4,
  parameter int MAX_PASS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BSW-1:0]    blk_idx,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [3:0]        ctl,
  output logic [NBLK-1:0]   blk_sel,
  output logic              wdt_arm,
  output logic [CNT_W-1:0]  wdt_period,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  localparam int BLK_BYTES = 2 * BLK_WORDS;
  localparam int WDT_CYC   = T_SE + T_SESU + T_CE + T_CESU + 1;
  localparam int PW        = $clog2(MAX_PASS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SWE, S_ARM, S_ESU, S_ERS, S_CE, S_CESU,
    S_EV, S_DWR, S_SEVR, S_RD, S_VOFF, S_SWOFF, S_DONE
  } st_t;

  st_t               st, nx;
  logic [CNT_W-1:0]  cnt;
  logic [BSW-1:0]    blk_r;
  logic [ADDR_W-1:0] base, addr;
  logic [PW-1:0]     pass;
  logic              clean, fail_r;

  function automatic logic [CNT_W-1:0] hold_of(st_t s);
    case (s)
      S_SWE:   return CNT_W'(T_SSWE - 1);
      S_ESU:   return CNT_W'(T_SESU - 1);
      S_ERS:   return CNT_W'(T_SE - 1);
      S_CE:    return CNT_W'(T_CE - 1);
      S_CESU:  return CNT_W'(T_CESU - 1);
      S_EV:    return CNT_W'(T_SEV - 1);
      S_SEVR:  return CNT_W'(T_SEVR - 1);
      S_VOFF:  return CNT_W'(T_CEV - 1);
      S_SWOFF: return CNT_W'(T_CSWE - 1);
      default: return '0;
    endcase
  endfunction

  wire word_ok  = &mem_rdata;
  wire last_adr = (addr == base + ADDR_W'(BLK_BYTES - 2));
  wire adv      = (st == S_IDLE) ? start : (cnt == '0);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  nx = S_SWE;
      S_SWE:   nx = S_ARM;
      S_ARM:   nx = S_ESU;
      S_ESU:   nx = S_ERS;
      S_ERS:   nx = S_CE;
      S_CE:    nx = S_CESU;
      S_CESU:  nx = S_EV;
      S_EV:    nx = S_DWR;
      S_DWR:   nx = S_SEVR;
      S_SEVR:  nx = S_RD;
      S_RD:    nx = (word_ok && !last_adr) ? S_DWR : S_VOFF;
      S_VOFF:  nx = (clean || pass == PW'(MAX_PASS)) ? S_SWOFF : S_ARM;
      S_SWOFF: nx = S_DONE;
      S_DONE:  nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; blk_r <= '0; base <= '0; addr <= '0;
      pass <= '0; clean <= 1'b0; fail_r <= 1'b0; blk_sel <= '0;
    end else if (adv) begin
      st  <= nx;
      cnt <= hold_of(nx);
      case (st)
        S_IDLE: begin
          blk_r <= blk_idx;
          base  <= ADDR_W'(blk_idx) * ADDR_W'(BLK_BYTES);
          pass  <= '0;
        end
        S_SWE:  blk_sel <= NBLK'(1) << blk_r;
        S_ESU:  pass <= pass + 1'b1;
        S_CESU: begin addr <= base; clean <= 1'b0; end
        S_RD: begin
          if (word_ok && last_adr) clean <= 1'b1;
          if (word_ok) addr <= addr + ADDR_W'(2);
        end
        S_VOFF: if (nx == S_SWOFF) begin blk_sel <= '0; fail_r <= !clean; end
        default: ;
      endcase
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ctl[0]     = (st != S_IDLE) && (st != S_SWOFF) && (st != S_DONE);
  assign ctl[1]     = (st == S_ESU) || (st == S_ERS) || (st == S_CE);
  assign ctl[2]     = (st == S_ERS);
  assign ctl[3]     = (st == S_EV) || (st == S_DWR) || (st == S_SEVR) || (st == S_RD);
  assign wdt_arm    = (st == S_ARM) || ctl[1];
  assign wdt_period = wdt_arm ? CNT_W'(WDT_CYC) : '0;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign fail       = done && fail_r;
  assign mem_we     = (st == S_DWR);
  assign mem_re     = (st == S_RD);
  assign mem_addr   = addr;
  assign mem_wdata  = 16'hFFFF;
endmodule

module flash_erase_seq_chk #(
  parameter int NBLK = 4, parameter int CNT_W = 16,
  parameter int T_SESU = 4, parameter int T_SE = 20, parameter int T_CE = 3,
  parameter int T_CESU = 2, parameter int MAX_PASS = 4
) (
  input logic clk, input logic rst_n, input logic start, input logic busy,
  input logic done, input logic fail, input logic [3:0] ctl,
  input logic [NBLK-1:0] blk_sel, input logic wdt_arm,
  input logic [CNT_W-1:0] wdt_period, input logic mem_we, input logic [15:0] mem_wdata
);
  int esu_len, ers_len, ce_len, passes;
  logic ers_q, esu_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esu_len <= 0; ers_len <= 0; ce_len <= 0; passes <= 0; ers_q <= 1'b0; esu_q <= 1'b0;
    end else begin
      esu_len <= ctl[1] ? esu_len + 1 : 0;
      ers_len <= ctl[2] ? ers_len + 1 : 0;
      ce_len  <= (ctl[1] && !ctl[2]) ? ce_len + 1 : 0;
      ers_q <= ctl[2]; esu_q <= ctl[1];
      if (start && !busy) passes <= 0;
      else if (ctl[2] && !ers_q) passes <= passes + 1;
    end
  end

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(blk_sel));
  p_wdt_armed_r2:  assert property (@(posedge clk) disable iff (!rst_n)
                     ctl[1] |-> (wdt_arm && int'(wdt_period) > T_SE + T_SESU + T_CE + T_CESU));
  p_wdt_off_r2:    assert property (@(posedge clk) disable iff (!rst_n) ctl[3] |-> !wdt_arm);
  p_nest_r3:       assert property (@(posedge clk) disable iff (!rst_n) ctl[2] |-> (ctl[1] && ctl[0]));
  p_setup_r3:      assert property (@(posedge clk) disable iff (!rst_n) $rose(ctl[2]) |-> esu_len >= T_SESU);
  p_pulse_max_r3:  assert property (@(posedge clk) disable iff (!rst_n) ctl[2] |-> ers_len < T_SE);
  p_hold_r4:       assert property (@(posedge clk) disable iff (!rst_n) (esu_q && !ctl[1]) |-> ce_len >= T_CE);
  p_pass_cap_r7:   assert property (@(posedge clk) disable iff (!rst_n) $rose(ctl[2]) |-> passes < MAX_PASS);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ctl == 4'b0 && blk_sel == '0));
  p_fail_done_r9:  assert property (@(posedge clk) disable iff (!rst_n) fail |-> done);
  p_we_verify_r10: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (ctl[3] && mem_wdata == 16'hFFFF));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .NBLK(NBLK), .CNT_W(CNT_W), .T_SESU(T_SESU), .T_SE(T_SE), .T_CE(T_CE),
  .T_CESU(T_CESU), .MAX_PASS(MAX_PASS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .ctl(ctl), .blk_sel(blk_sel), .wdt_arm(wdt_arm), .wdt_period(wdt_period),
  .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int NB = 4, WPB = 8, T_SSWE = 3, T_SESU = 4, T_SE = 20, T_CE = 3,
                 T_CESU = 2, T_SEV = 3, T_SEVR = 2, T_CEV = 3, T_CSWE = 4, MAXP = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] blk_idx = 0;
  logic busy, done, fail, wdt_arm, mem_we, mem_re;
  logic [3:0] ctl;
  logic [NB-1:0] blk_sel;
  logic [15:0] wdt_period, mem_wdata, mem_rdata;
  logic [9:0] mem_addr, lat;

  int checks = 0, errors = 0, cyc = 0;
  int need [0:NB*WPB-1];

  always #2 clk = ~clk;

  flash_erase_seq i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx), .busy(busy),
    .done(done), .fail(fail), .ctl(ctl), .blk_sel(blk_sel), .wdt_arm(wdt_arm),
    .wdt_period(wdt_period), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // flash model: latched address, per-word pulses still needed
  logic ers_m = 0;
  assign mem_rdata = (need[lat[5:1]] == 0) ? 16'hFFFF : 16'h5A5A;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) lat <= mem_addr;
    ers_m <= ctl[2];
    if (ers_m && !ctl[2])
      for (int i = 0; i < NB*WPB; i++)
        if (blk_sel[i/WPB] && need[i] > 0) need[i] <= need[i] - 1;
  end

  // observation at negedge
  logic wen_q = 0, esu_q = 0, ers_q = 0, ver_q = 0, first_we = 0;
  int t_wen_r, t_esu_r, t_ers_r, t_ers_f, t_ver_r, t_ver_f, t_wen_f, t_we;
  int g_sel, g_setup, g_ce, g_sev, g_sevr, g_cev, g_cswe, pulse_max, pulse_min;
  int pulses, reads, rd_first, rd_last, step_bad, mism, wdt_bad, pre_bad;
  logic [NB-1:0] sel_or;
  logic [9:0] we_addr, rd_prev;

  task automatic clear_stats();
    g_sel = 9999; g_setup = 9999; g_ce = 9999; g_sev = 9999; g_sevr = 9999;
    g_cev = 9999; g_cswe = 9999; pulse_max = 0; pulse_min = 9999; pulses = 0; reads = 0;
    rd_first = -1; rd_last = -1; step_bad = 0; mism = 0; wdt_bad = 0; pre_bad = 0; sel_or = '0;
  endtask

  always @(negedge clk) begin
    if (ctl[0] && !wen_q) t_wen_r = cyc;
    if (blk_sel != 0 && sel_or == 0) g_sel = cyc - t_wen_r;
    sel_or |= blk_sel;
    if (ctl[1] && !esu_q) t_esu_r = cyc;
    if (ctl[2] && !ers_q) begin t_ers_r = cyc; pulses++; if (cyc - t_esu_r < g_setup) g_setup = cyc - t_esu_r; end
    if (!ctl[2] && ers_q) begin
      t_ers_f = cyc;
      if (cyc - t_ers_r > pulse_max) pulse_max = cyc - t_ers_r;
      if (cyc - t_ers_r < pulse_min) pulse_min = cyc - t_ers_r;
    end
    if (!ctl[1] && esu_q && cyc - t_ers_f < g_ce) g_ce = cyc - t_ers_f;
    if (ctl[3] && !ver_q) begin t_ver_r = cyc; first_we = 1; end
    if (!ctl[3] && ver_q) t_ver_f = cyc;
    if (!ctl[0] && wen_q) begin t_wen_f = cyc; if (cyc - t_ver_f < g_cev) g_cev = cyc - t_ver_f; end
    if (done && cyc - t_wen_f < g_cswe) g_cswe = cyc - t_wen_f;
    if (ctl[1] && (!wdt_arm || wdt_period <= 16'(T_SE + T_SESU + T_CE + T_CESU))) wdt_bad++;
    if (ctl[3] && wdt_arm) wdt_bad++;
    if (mem_we && (!ctl[3] || mem_wdata != 16'hFFFF)) pre_bad++;
    if (mem_we) begin
      t_we = cyc; we_addr = mem_addr;
      if (first_we) begin first_we = 0; if (cyc - t_ver_r < g_sev) g_sev = cyc - t_ver_r; end
    end
    if (mem_re) begin
      if (cyc - t_we < g_sevr) g_sevr = cyc - t_we;
      if (mem_addr != we_addr) mism++;
      if (reads > 0 && mem_addr != rd_prev + 10'd2 && mem_addr != 10'(rd_first)) step_bad++;
      if (rd_first < 0) rd_first = int'(mem_addr);
      rd_last = int'(mem_addr); rd_prev = mem_addr; reads++;
    end
    wen_q = ctl[0]; esu_q = ctl[1]; ers_q = ctl[2]; ver_q = ctl[3];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  int got_fail;
  task automatic run(input int blk, input bit poke_busy);
    int n = 0;
    clear_stats();
    @(negedge clk); start = 1; blk_idx = 2'(blk);
    @(negedge clk); start = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (poke_busy && n == 40) begin start = 1; blk_idx = 2'(blk ^ 2); end
      if (poke_busy && n == 41) start = 0;
    end
    got_fail = fail;
    chk(done, "R8 done reached", n, 0);
    @(negedge clk);
  endtask

  task automatic timing_checks();
    chk(g_sel >= T_SSWE, "R1 wen-to-select gap", g_sel, T_SSWE);
    chk(wdt_bad == 0, "R2 watchdog window", wdt_bad, 0);
    chk(g_setup >= T_SESU, "R3 setup-to-erase gap", g_setup, T_SESU);
    chk(pulse_max <= T_SE && pulse_min == T_SE, "R3 erase pulse length", pulse_max, T_SE);
    chk(g_ce >= T_CE, "R4 erase-to-setup-drop gap", g_ce, T_CE);
    chk(g_sev >= T_SEV, "R5 verify-to-dummy-write gap", g_sev, T_SEV);
    chk(g_sevr >= T_SEVR + 1, "R6 write-to-read gap", g_sevr, T_SEVR + 1);
    chk(mism == 0 && step_bad == 0, "R6 read address order", mism + step_bad, 0);
    chk(g_cev >= T_CEV, "R8 verify-drop to wen-drop", g_cev, T_CEV);
    chk(g_cswe >= T_CSWE, "R8 wen-drop to done", g_cswe, T_CSWE);
    chk(pre_bad == 0, "R10 writes only in verify", pre_bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R8 idle after reset", busy, 0);
    chk(ctl == 0 && blk_sel == 0 && !mem_we && !mem_re, "R10 outputs quiet after reset", ctl, 0);
  endtask

  task automatic t_clean();
    for (int i = 0; i < WPB; i++) need[1*WPB + i] = 1;
    run(1, 0);
    timing_checks();
    chk(sel_or == 4'b0010, "R1 block select one-hot", sel_or, 2);
    chk(pulses == 1, "R7 clean block one pulse", pulses, 1);
    chk(reads == WPB, "R6 read count", reads, WPB);
    chk(rd_first == 16 && rd_last == 30, "R6 block range", rd_last, 30);
    chk(got_fail == 0, "R9 no fail on clean", got_fail, 0);
  endtask

  task automatic t_retry();
    for (int i = 0; i < WPB; i++) need[2*WPB + i] = 1;
    need[2*WPB + 3] = 3;
    run(2, 0);
    timing_checks();
    chk(pulses == 3, "R7 retry pulses", pulses, 3);
    chk(reads == 16, "R7 early abort read count", reads, 16);
    chk(got_fail == 0, "R9 no fail after retry", got_fail, 0);
  endtask

  task automatic t_exhaust();
    for (int i = 0; i < WPB; i++) need[3*WPB + i] = 1;
    need[3*WPB + 7] = 9;
    run(3, 0);
    chk(pulses == MAXP, "R7 pass cap", pulses, MAXP);
    chk(reads == MAXP * WPB, "R7 reads with stuck last word", reads, MAXP * WPB);
    chk(rd_last == 62, "R6 last block end address", rd_last, 62);
    chk(got_fail == 1, "R9 fail after cap", got_fail, 1);
    chk(g_cswe >= T_CSWE && g_cev >= T_CEV, "R8 teardown on fail", g_cswe, T_CSWE);
  endtask

  task automatic t_busy();
    for (int i = 0; i < WPB; i++) need[i] = 1;
    run(0, 1);
    chk(sel_or == 4'b0001, "R1 start while busy ignored (select)", sel_or, 1);
    chk(pulses == 1 && reads == WPB, "R1 start while busy ignored (pulses)", pulses, 1);
    repeat (30) @(negedge clk);
    chk(!busy, "R1 no queued run", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < NB*WPB; i++) need[i] = 0;
    lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_retry();
    t_exhaust();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule